// File: doc/BRIEF.md
# Programmable 32-bit Event Timer

A general-purpose interval timer for a processor subsystem. Software programs a period and a control word through a simple register port, then launches the counter. Each count event comes either from a one-cycle internal tick enable or from a rising edge of an unsynchronized external clock pin. When the count completes a period, the timer restarts from zero. It fires a one-cycle interrupt pulse and updates a status output that a DMA engine can use for pacing.

The status output has two signalling styles. In pulse mode it is high for one or two system clock cycles per period, and a control bit picks the width. In clock mode it toggles on every period completion, which gives a square wave at half the completion rate. The current level of the status output can be read back in the control word. Launch and hold are separate bits. Launching needs both set in one write. Clearing hold freezes the count without losing it. The register port is plain control: a write strobe with address and data, and a combinational read path. It has no handshake or back-pressure.

Top module: `evt_timer32`

## Requirements
- R1: After reset every register reads zero, the timer is idle, and tint and tstat are low. Address map: 0 control, 1 period, 2 counter, 3 reads zero.
- R2: Control read layout: bit 11 status level, bit 9 source select, bit 8 mode, bit 7 hold-release, bit 6 launch, bit 4 width. Bit 6 always reads 0, and all other bits read 0 whatever was written.
- R3: A control write with bit 6 = 1 and bit 7 = 1 clears the counter and makes the timer active. A control write with bit 6 = 0, or with bit 7 = 0, neither clears nor launches.
- R4: While idle, the counter never changes except by a direct counter write.
- R5: With bit 7 = 0 the counter holds its value. The counter can be written at any time, and such a write takes precedence over a count event in the same cycle.
- R6: Bit 9 = 1 counts cycles with tick_int high. Bit 9 = 0 counts rising edges of ext_clk after a two-flop synchronizer, once per edge, taking effect on the third rising clk edge after the pin rises. tick_int is then ignored.
- R7: On a count event, if counter+1 >= period the counter becomes 0 and a period completes. Otherwise the counter increments. A period of 0 completes on every event.
- R8: tint is high for exactly the cycle that follows each period completion.
- R9: In pulse mode (bit 8 = 0), a completion drives tstat high for 1 cycle if bit 4 = 0, or for 2 cycles if bit 4 = 1, starting in the cycle after the completion.
- R10: In clock mode (bit 8 = 1), tstat toggles in the cycle after each completion and otherwise holds.
- R11: Control bit 11 always equals the present tstat level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 1 | Internal count enable, one event per high cycle |
| ext_clk | input | 1 | Asynchronous external count clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tint | output | 1 | Interrupt pulse per period completion |
| tstat | output | 1 | Status/DMA event output |

## Verification
On every cycle, the embedded properties check several things. The counter stays frozen while idle or held, unless a write occurs. A completion always leaves the counter at zero. A launch always makes the timer active. The synchronized edge detector never fires twice in a row. The clock-mode level changes only after a completion, and a pulse always starts after a completion. Other behaviours appear only in the bench's scenarios. These are the exact wrap point for each period value, including zero and a counter written above the period. They also include the pulse widths, the control read layout, the precedence of software writes, and the latency of the external edge path. For these, a cycle-level reference model in the bench is compared on every cycle against tint, tstat and the read data.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    A_CTL  = 2'd0,
    A_PRD  = 2'd1,
    A_CNT  = 2'd2,
    A_NONE = 2'd3
  } addr_e;

  localparam int B_STAT = 11;
  localparam int B_SRC  = 9;
  localparam int B_MODE = 8;
  localparam int B_RUN  = 7;
  localparam int B_GO   = 6;
  localparam int B_WID  = 4;

  typedef struct packed {
    logic src_int;
    logic clk_mode;
    logic run;
    logic wide;
  } ctl_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_ACTIVE = 1'b1} st_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = SYNC;

  logic [LAST:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[LAST-1:0], async_in};
  end

  assign rise = sh[LAST-1] & ~sh[LAST];

  a_r6_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_ctl_regs.sv
module tmr_ctl_regs
  import evt_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output ctl_t         ctl,
  output logic [W-1:0] prd,
  output logic         active,
  output logic         start,
  output logic         cnt_ld
);
  logic ctl_wr;
  st_e  st;

  assign ctl_wr = wr_en && (addr == A_CTL);
  assign start  = ctl_wr && wdata[B_GO] && wdata[B_RUN];
  assign cnt_ld = wr_en && (addr == A_CNT);
  assign active = (st == ST_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      prd <= '0;
      st  <= ST_IDLE;
    end else begin
      if (ctl_wr) begin
        ctl.src_int  <= wdata[B_SRC];
        ctl.clk_mode <= wdata[B_MODE];
        ctl.run      <= wdata[B_RUN];
        ctl.wide     <= wdata[B_WID];
      end
      if (wr_en && (addr == A_PRD)) prd <= wdata;
      if (start) st <= ST_ACTIVE;
    end
  end

  a_r3_launch_active: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         start,
  input  logic         cnt_ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] prd,
  output logic [W-1:0] cnt,
  output logic         hit,
  output logic         tint
);
  localparam int WX = W + 1;

  logic [WX-1:0] nxt;

  assign nxt = {1'b0, cnt} + WX'(1);
  assign hit = cnt_en && !start && !cnt_ld && (nxt >= {1'b0, prd});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tint <= 1'b0;
    end else begin
      tint <= hit;
      if (start)       cnt <= '0;
      else if (cnt_ld) cnt <= ld_val;
      else if (hit)    cnt <= '0;
      else if (cnt_en) cnt <= nxt[W-1:0];
    end
  end

  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tint |-> (cnt == '0));
endmodule

// File: rtl/tmr_out_gen.sv
module tmr_out_gen #(
  parameter int PW_SHORT = 1,
  parameter int PW_LONG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clk_mode,
  input  logic wide,
  output logic tstat
);
  localparam int PCW = $clog2(PW_LONG + 1);

  logic [PCW-1:0] pc;
  logic           tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      tog <= 1'b0;
    end else begin
      if (fire)            pc <= wide ? PCW'(PW_LONG) : PCW'(PW_SHORT);
      else if (pc != '0)   pc <= pc - PCW'(1);
      if (fire)            tog <= ~tog;
    end
  end

  assign tstat = clk_mode ? tog : (pc != '0);

  a_r10_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fire) |-> (tog == $past(tog)));
  a_r9_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pc != '0));
endmodule

// File: rtl/evt_timer32.sv
module evt_timer32
  import evt_timer_pkg::*;
#(
  parameter int W        = 32,
  parameter int SYNC     = 2,
  parameter int PW_SHORT = 1,
  parameter int PW_LONG  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_int,
  input  logic         ext_clk,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         tint,
  output logic         tstat
);
  ctl_t         ctl;
  logic [W-1:0] prd;
  logic [W-1:0] cnt;
  logic         active, start, cnt_ld, ext_rise, cnt_en, hit;

  tmr_edge_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise)
  );

  tmr_ctl_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .ctl(ctl), .prd(prd), .active(active),
    .start(start), .cnt_ld(cnt_ld)
  );

  assign cnt_en = active && ctl.run && (ctl.src_int ? tick_int : ext_rise);

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start(start),
    .cnt_ld(cnt_ld), .ld_val(reg_wdata), .prd(prd), .cnt(cnt),
    .hit(hit), .tint(tint)
  );

  tmr_out_gen #(.PW_SHORT(PW_SHORT), .PW_LONG(PW_LONG)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(hit), .clk_mode(ctl.clk_mode),
    .wide(ctl.wide), .tstat(tstat)
  );

  always_comb begin
    reg_rdata = '0;
    case (addr_e'(reg_addr))
      A_CTL: begin
        reg_rdata[B_STAT] = tstat;
        reg_rdata[B_SRC]  = ctl.src_int;
        reg_rdata[B_MODE] = ctl.clk_mode;
        reg_rdata[B_RUN]  = ctl.run;
        reg_rdata[B_WID]  = ctl.wide;
      end
      A_PRD:   reg_rdata = prd;
      A_CNT:   reg_rdata = cnt;
      default: reg_rdata = '0;
    endcase
  end

  a_r4_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!active && !reg_wr) |-> $stable(cnt));
  a_r5_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctl.run && !reg_wr) |-> $stable(cnt));
endmodule

// File: tb/evt_timer32_test.sv
`timescale 1ns/1ps
module evt_timer32_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick_int = 1'b0, ext_clk = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire         tint, tstat;

  evt_timer32 uut (
    .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .ext_clk(ext_clk),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tint(tint), .tstat(tstat)
  );

  always #2.5 clk = ~clk;

  // reference model state
  bit        m_s1, m_s2, m_s3, m_act, m_src, m_mode, m_run, m_wide, m_tint, m_tog;
  bit [31:0] m_cnt, m_prd;
  bit [1:0]  m_pc;
  int        checks = 0, errors = 0;
  string     tag = "R1";

  function automatic bit m_tstat();
    return m_mode ? m_tog : (m_pc != 2'd0);
  endfunction

  function automatic bit [31:0] m_read(input bit [1:0] a);
    bit [31:0] v = '0;
    case (a)
      2'd0: begin
        v[11] = m_tstat(); v[9] = m_src; v[8] = m_mode; v[7] = m_run; v[4] = m_wide;
      end
      2'd1: v = m_prd;
      2'd2: v = m_cnt;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_step();
    bit rise, en, cwr, start, cld, hit;
    rise  = m_s2 & ~m_s3;
    en    = m_act && m_run && (m_src ? tick_int : rise);
    cwr   = reg_wr && reg_addr == 2'd0;
    start = cwr && reg_wdata[6] && reg_wdata[7];
    cld   = reg_wr && reg_addr == 2'd2;
    hit   = en && !start && !cld && ({1'b0, m_cnt} + 33'd1 >= {1'b0, m_prd});
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
    if (start)    m_cnt = 0;
    else if (cld) m_cnt = reg_wdata;
    else if (hit) m_cnt = 0;
    else if (en)  m_cnt = m_cnt + 1;
    if (reg_wr && reg_addr == 2'd1) m_prd = reg_wdata;
    if (hit) m_pc = m_wide ? 2'd2 : 2'd1;
    else if (m_pc != 0) m_pc = m_pc - 2'd1;
    if (hit) m_tog = ~m_tog;
    m_tint = hit;
    if (cwr) begin
      m_src = reg_wdata[9]; m_mode = reg_wdata[8]; m_run = reg_wdata[7]; m_wide = reg_wdata[4];
    end
    if (start) m_act = 1'b1;
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input bit [1:0] a, input bit [31:0] d, input bit tk, input bit ex);
    reg_wr = w; reg_addr = a; reg_wdata = d; tick_int = tk; ext_clk = ex;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("tint", {31'b0, tint}, {31'b0, m_tint});
    chk("tstat", {31'b0, tstat}, {31'b0, m_tstat()});
    chk("rdata", reg_rdata, m_read(a));
  endtask

  task automatic idle(input int n, input bit [1:0] a, input int pct, input bit extr);
    for (int i = 0; i < n; i++)
      cyc(0, a, 0, ($urandom % 100) < pct, extr ? (ext_clk ^ ($urandom % 3 == 0)) : ext_clk);
  endtask

  task automatic wr(input bit [1:0] a, input bit [31:0] d);
    cyc(1, a, d, 1'b0, ext_clk);
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state on all addresses
    tag = "R1";
    for (int a = 0; a < 4; a++) idle(1, 2'(a), 0, 0);
    // R4: idle timer ignores both sources
    tag = "R4";
    wr(1, 3);
    idle(20, 2, 100, 1);
    wr(0, 32'h280);
    idle(10, 2, 100, 0);
    wr(2, 7);
    idle(4, 2, 100, 0);
    // R3: launch needs both bits
    tag = "R3";
    wr(0, 32'h2C0);
    idle(8, 2, 100, 0);
    wr(0, 32'h240);
    idle(4, 2, 100, 0);
    wr(0, 32'h280);
    idle(5, 2, 100, 0);
    wr(0, 32'h2C0);
    idle(3, 2, 100, 0);
    // R2: read layout and reserved bits
    tag = "R2";
    wr(0, 32'hFFFF_FFFF);
    idle(3, 0, 100, 0);
    idle(1, 3, 0, 0);
    // R5: hold and software counter writes
    tag = "R5";
    wr(1, 9);
    wr(0, 32'h2C0);
    idle(3, 2, 100, 0);
    wr(0, 32'h200);
    idle(6, 2, 100, 0);
    wr(2, 1);
    idle(3, 2, 100, 0);
    wr(0, 32'h280);
    cyc(1, 2, 32'd5, 1'b1, ext_clk);
    idle(6, 2, 100, 0);
    // R6: external source, internal ticks ignored
    tag = "R6";
    wr(1, 4);
    wr(0, 32'h0C0);
    idle(10, 2, 100, 0);
    for (int k = 0; k < 12; k++) begin
      for (int j = 0; j < 3; j++) cyc(0, 2, 0, 1'b1, 1'b1);
      for (int j = 0; j < 3; j++) cyc(0, 2, 0, 1'b1, 1'b0);
    end
    // R7: wrap point, zero period, counter above period
    tag = "R7";
    wr(1, 2);
    wr(0, 32'h2C0);
    wr(2, 10);
    idle(6, 2, 100, 0);
    wr(1, 0);
    idle(5, 2, 100, 0);
    // R8: interrupt pulses
    tag = "R8";
    wr(1, 3);
    wr(0, 32'h2C0);
    idle(20, 2, 100, 0);
    // R9: pulse widths
    tag = "R9";
    wr(1, 4);
    wr(0, 32'h2C0);
    idle(15, 0, 100, 0);
    wr(0, 32'h2D0);
    idle(15, 0, 100, 0);
    wr(1, 1);
    idle(8, 0, 100, 0);
    // R10: clock mode
    tag = "R10";
    wr(1, 3);
    wr(0, 32'h3C0);
    idle(20, 0, 100, 0);
    // R11: status bit follows the pin
    tag = "R11";
    wr(0, 32'h2D0);
    idle(20, 0, 60, 0);
    // R7: constrained random configurations
    tag = "R7";
    for (int it = 0; it < 40; it++) begin
      bit [31:0] cfg;
      cfg = {22'b0, 1'($urandom), 1'($urandom), 2'b11, 1'b0, 1'($urandom), 4'b0};
      wr(1, ($urandom % 4 == 0) ? ($urandom % 40) : ($urandom % 6));
      wr(0, cfg);
      for (int c = 0; c < 40; c++) begin
        int r;
        r = $urandom % 20;
        if (r == 0)      wr(2, $urandom % 8);
        else if (r == 1) wr(0, {22'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'($urandom), 4'b0});
        else             idle(1, 2'($urandom), 70, 1);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule